// File: doc/BRIEF.md
# Skewed Eight-Bank Stride Address Generator

This block turns one vector access request into the per-lane locations of an eight-bank scratch-pad memory. A request carries a scanning-point address, a pattern kind and the stride or row-length values that the pattern needs. For each of `LANES` lanes the block forms the element address. It splits that address into a bank number and an in-bank offset using a skewed placement, so that accesses along rows and down columns both spread over all banks.

For the accepted request, the block also states whether the access is conflict-free, meaning that no bank is asked for two elements in the same cycle. It gives the read crossbar a per-bank routing map: which lane each bank serves, and whether the bank is used at all. Requests enter and results leave through valid/ready handshakes. The results sit in one register stage, so one access can be produced every cycle.

Top module: `stride_agen`

## Requirements
- R1: Pattern code 0 (burst): lane k addresses `base + k`.
- R2: Pattern code 1 (column): lane k addresses `base + k*row_len`.
- R3: Pattern code 2 (free stride): lane k addresses `base + k*stride`. The stride is a two's-complement value, and every address wraps modulo 2^AW.
- R4: Pattern code 3 (block): lane k addresses `base + (k mod BLK_W) + (k div BLK_W)*row_len`. BLK_W defaults to 4.
- R5: For an element address a, the offset output is `floor(a/8)` (AW-3 bits) and the bank is `(a mod 8 + floor(a/8) mod 8) mod 8` (3 bits). Lane k occupies slice k of each packed output.
- R6: `out_conflict` is high exactly when two or more lanes carry the same bank number. It is valid in the same cycle as the bank and offset outputs.
- R7: Bit b of `out_bank_used` is set exactly when some lane maps to bank b. Slice b of `out_lane_of_bank` holds the lowest such lane index, and it is 0 for an unused bank.
- R8: `in_ready` is high when the output register is empty or is being drained. An accepted request appears at the outputs with `out_valid` on the next cycle. The outputs hold steady while `out_valid` is high and `out_ready` is low.
- R9: While and after synchronous reset, `out_valid` is low and `in_ready` is high.
- R10: A burst that starts on a multiple of 8, and a column pattern with row length 8, are conflict-free at any base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_base | input | AW | Scanning-point address |
| in_pat | input | 2 | Pattern code (0 burst, 1 column, 2 stride, 3 block) |
| in_stride | input | AW | Signed stride for pattern 2 |
| in_row_len | input | AW | Row length for patterns 1 and 3 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_bank | output | LANES x 3 | Bank number per lane |
| out_offs | output | LANES x (AW-3) | In-bank offset per lane |
| out_conflict | output | 1 | Two lanes share a bank |
| out_bank_used | output | 8 | Bank served by some lane |
| out_lane_of_bank | output | 8 x clog2(LANES) | Lowest lane served by each bank |

## Verification
A wrong lane multiplier or a wrong skew shows up as a wrong bank or offset on the very result that carries that request, so a scoreboard compare catches it in the output cycle. A fault in the duplicate search or in the lane priority shows only on accesses where banks collide or where one bank is reached from several lanes. The stimulus therefore mixes conflict-free row-aligned and column accesses with unaligned bursts, wide column strides, negative strides and blocks. A broken stall path shows up as output slices that change while the consumer is holding off, so the result register is checked across stalls cycle by cycle.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int NBANK  = 8;
    localparam int BANK_W = 3;

    typedef enum logic [1:0] {
        PAT_BURST  = 2'd0,
        PAT_COLUMN = 2'd1,
        PAT_STRIDE = 2'd2,
        PAT_BLOCK  = 2'd3
    } pat_e;

    // Skewed placement: low three address bits plus low three row-index bits.
    function automatic logic [BANK_W-1:0] skew_bank(
        input logic [BANK_W-1:0] col_bits,
        input logic [BANK_W-1:0] row_bits
    );
        return col_bits + row_bits;
    endfunction

endpackage

// File: rtl/sag_lane_addr.sv
module sag_lane_addr
    import sag_pkg::*;
#(
    parameter int AW       = 16,
    parameter int LANE_IDX = 0,
    parameter int BLK_W    = 4
) (
    input  logic [AW-1:0]        base,
    input  pat_e                 pat,
    input  logic [AW-1:0]        stride,
    input  logic [AW-1:0]        row_len,
    output logic [BANK_W-1:0]    bank,
    output logic [AW-BANK_W-1:0] offs
);
    localparam logic [AW-1:0] K_LIN = AW'(LANE_IDX);
    localparam logic [AW-1:0] K_COL = AW'(LANE_IDX % BLK_W);
    localparam logic [AW-1:0] K_ROW = AW'(LANE_IDX / BLK_W);

    logic [AW-1:0] addr;

    always_comb begin
        unique case (pat)
            PAT_BURST:  addr = base + K_LIN;
            PAT_COLUMN: addr = base + K_LIN * row_len;
            PAT_STRIDE: addr = base + K_LIN * stride;
            default:    addr = base + K_COL + K_ROW * row_len;
        endcase
    end

    assign offs = addr[AW-1:BANK_W];
    assign bank = skew_bank(addr[BANK_W-1:0], addr[2*BANK_W-1:BANK_W]);

endmodule

// File: rtl/sag_route.sv
module sag_route
    import sag_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0][BANK_W-1:0] bank,
    output logic                         conflict,
    output logic [NBANK-1:0]             used,
    output logic [NBANK-1:0][LANE_W-1:0] lane_of_bank
);
    // Walk from the highest lane down so the lowest lane is written last.
    always_comb begin
        conflict     = 1'b0;
        used         = '0;
        lane_of_bank = '0;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (used[bank[k]]) conflict = 1'b1;
            used[bank[k]]         = 1'b1;
            lane_of_bank[bank[k]] = LANE_W'(k);
        end
    end

endmodule

// File: rtl/stride_agen.sv
module stride_agen
    import sag_pkg::*;
#(
    parameter int AW     = 16,
    parameter int LANES  = 8,
    parameter int BLK_W  = 4,
    parameter int LANE_W = $clog2(LANES),
    parameter int OFFS_W = AW - 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [AW-1:0]                in_base,
    input  logic [1:0]                   in_pat,
    input  logic [AW-1:0]                in_stride,
    input  logic [AW-1:0]                in_row_len,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [LANES-1:0][2:0]        out_bank,
    output logic [LANES-1:0][OFFS_W-1:0] out_offs,
    output logic                         out_conflict,
    output logic [7:0]                   out_bank_used,
    output logic [7:0][LANE_W-1:0]       out_lane_of_bank
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFFS_W-1:0] offs;
    } loc_t;

    loc_t loc_d [LANES];
    loc_t loc_q [LANES];
    logic valid_q;
    logic take;

    assign in_ready  = !valid_q || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = valid_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sag_lane_addr #(
            .AW       (AW),
            .LANE_IDX (g),
            .BLK_W    (BLK_W)
        ) u_addr (
            .base    (in_base),
            .pat     (pat_e'(in_pat)),
            .stride  (in_stride),
            .row_len (in_row_len),
            .bank    (loc_d[g].bank),
            .offs    (loc_d[g].offs)
        );

        always_ff @(posedge clk) begin
            if (take) loc_q[g] <= loc_d[g];
        end

        assign out_bank[g] = loc_q[g].bank;
        assign out_offs[g] = loc_q[g].offs;
    end

    always_ff @(posedge clk) begin
        if (rst)           valid_q <= 1'b0;
        else if (in_ready) valid_q <= in_valid;
    end

    sag_route #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_route (
        .bank         (out_bank),
        .conflict     (out_conflict),
        .used         (out_bank_used),
        .lane_of_bank (out_lane_of_bank)
    );

endmodule

// File: rtl/stride_agen_chk.sv
module stride_agen_chk #(
    parameter int LANES  = 8,
    parameter int OFFS_W = 13
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         in_valid,
    input logic                         in_ready,
    input logic                         out_valid,
    input logic                         out_ready,
    input logic [LANES-1:0][2:0]        out_bank,
    input logic [LANES-1:0][OFFS_W-1:0] out_offs,
    input logic                         out_conflict,
    input logic [7:0]                   out_bank_used
);
    a_r9_reset_idle: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r8_accept_next: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_bank) && $stable(out_offs));

    a_r6_free_fills_banks: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_conflict |-> $countones(out_bank_used) == LANES);

    a_r6_clash_leaves_gap: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_conflict |-> $countones(out_bank_used) < LANES);

endmodule

bind stride_agen stride_agen_chk #(
    .LANES  (LANES),
    .OFFS_W (OFFS_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_bank      (out_bank),
    .out_offs      (out_offs),
    .out_conflict  (out_conflict),
    .out_bank_used (out_bank_used)
);

// File: tb/sim_stride_agen.sv
module sim_stride_agen;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LN = 8;
    localparam int OW = AW - 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [AW-1:0] in_base = '0;
    logic [1:0] in_pat = '0;
    logic [AW-1:0] in_stride = '0;
    logic [AW-1:0] in_row_len = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [LN-1:0][2:0] out_bank;
    logic [LN-1:0][OW-1:0] out_offs;
    logic out_conflict;
    logic [7:0] out_bank_used;
    logic [7:0][2:0] out_lane_of_bank;

    always #(CLK_PERIOD/2) clk = ~clk;

    stride_agen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_base(in_base), .in_pat(in_pat), .in_stride(in_stride),
        .in_row_len(in_row_len), .out_valid(out_valid), .out_ready(out_ready),
        .out_bank(out_bank), .out_offs(out_offs), .out_conflict(out_conflict),
        .out_bank_used(out_bank_used), .out_lane_of_bank(out_lane_of_bank)
    );

    typedef struct packed {
        logic [LN-1:0][2:0]  bank;
        logic [LN-1:0][OW-1:0] offs;
        logic                conflict;
        logic [7:0]          used;
        logic [7:0][2:0]     map;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int n_run = 0;
    int n_fail = 0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [AW-1:0] b, input int pat,
                                   input logic [AW-1:0] s, input logic [AW-1:0] row);
        exp_t e;
        logic [AW-1:0] a;
        e = '0;
        for (int k = 0; k < LN; k++) begin
            case (pat)
                0: a = b + AW'(k);
                1: a = b + AW'(k) * row;
                2: a = b + AW'(k) * s;
                default: a = b + AW'(k % 4) + AW'(k / 4) * row;
            endcase
            e.offs[k] = OW'(a / 8);
            e.bank[k] = 3'(((a % 8) + ((a / 8) % 8)) % 8);
        end
        for (int k = 0; k < LN; k++)
            for (int j = k + 1; j < LN; j++)
                if (e.bank[k] == e.bank[j]) e.conflict = 1'b1;
        for (int k = LN - 1; k >= 0; k--) begin
            e.used[e.bank[k]] = 1'b1;
            e.map[e.bank[k]] = 3'(k);
        end
        return e;
    endfunction

    task automatic send(input logic [AW-1:0] b, input int pat, input logic [AW-1:0] s,
                        input logic [AW-1:0] row, input string tag);
        in_valid = 1'b1; in_base = b; in_pat = 2'(pat); in_stride = s; in_row_len = row;
        forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk); #1;
        end
        exp_q.push_back(model(b, pat, s, row));
        tag_q.push_back(tag);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Consumer back-pressure
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            out_ready = !(stall_en && (cyc % 3 != 0));
        end
    end

    // Monitor / scoreboard
    initial begin
        bit held = 1'b0;
        logic [LN-1:0][2:0] hb;
        logic [LN-1:0][OW-1:0] ho;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (held) begin
                    check(out_valid && out_bank == hb && out_offs == ho, "R8 hold",
                          128'(out_bank), 128'(hb));
                end
                held = out_valid && !out_ready;
                hb = out_bank; ho = out_offs;
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected result", 128'(out_bank), 128'(0));
                    end else begin
                        exp_t e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(out_bank == e.bank, {t, " R5 bank"}, 128'(out_bank), 128'(e.bank));
                        check(out_offs == e.offs, {t, " R5 offs"}, 128'(out_offs), 128'(e.offs));
                        check(out_conflict == e.conflict, {t, " R6 conflict"},
                              128'(out_conflict), 128'(e.conflict));
                        check(out_bank_used == e.used, {t, " R7 used"},
                              128'(out_bank_used), 128'(e.used));
                        check(out_lane_of_bank == e.map, {t, " R7 map"},
                              128'(out_lane_of_bank), 128'(e.map));
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(!out_valid, "R9 valid in reset", 128'(out_valid), 128'(0));
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R9 idle after reset",
              128'({out_valid, in_ready}), 128'(2'b01));
        @(posedge clk); #1;

        send(16'h0000, 0, 16'h0000, 16'h0000, "R1 R10 aligned burst");
        send(16'h0005, 0, 16'h0000, 16'h0000, "R1 R6 unaligned burst");
        send(16'h0040, 0, 16'h0000, 16'h0000, "R1 R10 aligned burst row8");
        send(16'hFFFC, 0, 16'h0000, 16'h0000, "R1 R3 burst wrap");
        send(16'h0003, 1, 16'h0000, 16'h0008, "R2 R10 column");
        send(16'h0000, 1, 16'h0000, 16'h0010, "R2 R6 column row16");
        send(16'h0064, 2, 16'h0009, 16'h0000, "R3 diagonal");
        send(16'h0003, 2, 16'hFFFF, 16'h0000, "R3 negative wrap");
        send(16'h0020, 2, 16'hFFF7, 16'h0000, "R3 anti diagonal");
        send(16'h0000, 2, 16'h0004, 16'h0000, "R3 R7 radix stride");
        send(16'h0000, 3, 16'h0000, 16'h0004, "R4 block row4");
        send(16'h000A, 3, 16'h0000, 16'h0008, "R4 R6 block row8");
        repeat (2) @(posedge clk);
        #1;
        stall_en = 1'b1;
        send(16'h1238, 1, 16'h0000, 16'h0008, "R8 R10 column stalled");
        send(16'h0007, 2, 16'h0007, 16'h0000, "R8 R3 stride7 stalled");
        send(16'h0100, 3, 16'h0000, 16'h0020, "R8 R4 block stalled");
        send(16'h0011, 0, 16'h0000, 16'h0000, "R8 R1 burst stalled");
        repeat (40) @(posedge clk);
        check(exp_q.size() == 0, "R8 all results drained", 128'(exp_q.size()), 128'(0));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule